// File: doc/BRIEF.md
# Per-Function Outbound Request Stop Gate

This block sits on an endpoint's outbound request path, between the internal masters and the PCIe core. It tracks one stop bit per physical function. A function's stop bit goes high on its own when that function enters function level reset, and it stays high until software clears it. While the bit is high, posted and non-posted requests from that function are accepted and thrown away, so they never reach the core. Each thrown-away non-posted request gets an error completion at once, so the requester does not wait for a timeout. Completions travelling outbound are never held back.

Every discard sets a sticky per-function debug flag, and the interrupt line is high while any debug flag is set. Software sees two small registers through a simple write/read port. Address 0 holds the stop bits and address 1 holds the debug flags, both write-1-to-clear. The MAC reset clears all state. The chip soft reset only empties the pending error completion and leaves the stop bits and the debug flags alone.

Top module: `req_stop_gate`

## Requirements
- R1: A high `flr_enter[i]` sets stop bit i at the next clock edge. The stop register, read with `reg_addr`=0, shows stop bit i at data bit i, and every bit at or above NFUNC reads 0.
- R2: A stop bit is cleared only by a register write to address 0 with a 1 at its position. Writing 0 leaves it unchanged. If `flr_enter[i]` and a clear of bit i fall in the same cycle, the bit stays set.
- R3: The request kind is encoded as 2'b00 posted, 2'b01 non-posted, 2'b10 completion and 2'b11 other. A posted or non-posted request whose function is stopped is accepted (`req_ready`=1, whatever `core_ready` is) and `core_valid` stays 0.
- R4: Completions, the 2'b11 kind, requests from functions whose stop bit is clear, and function numbers at or above NFUNC all pass through unchanged. For these, `core_valid`=`req_valid`, `req_ready`=`core_ready`, and all fields are copied.
- R5: A non-posted request discarded in cycle N makes `errcpl_valid` high from cycle N+1. The completion carries the request's function, tag and requester ID and holds them until `errcpl_ready` takes it. One completion is issued per discarded non-posted request.
- R6: A non-posted request to a stopped function stalls (`req_ready`=0) while an error completion is pending and `errcpl_ready` is low. Posted discards are still accepted during that time.
- R7: Every accepted discard sets debug flag i of its function at the next edge. The flags read at `reg_addr`=1, bit i. They stay set until a write to address 1 with a 1 at that position, and writing 0 has no effect.
- R8: `irq` is high exactly when at least one debug flag is set.
- R9: A low `rst_n` clears the stop bits, the debug flags and any pending error completion. A high `soft_rst` clears only the pending error completion and stalls non-posted discards for that cycle. The stop bits and the debug flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | MAC reset, active low, asynchronous |
| soft_rst | input | 1 | Chip soft reset, synchronous, active high |
| flr_enter | input | NFUNC | Per-function pulse on entry to function level reset |
| req_valid | input | 1 | Outbound request valid |
| req_ready | output | 1 | Outbound request accepted |
| req_func | input | FUNC_W | Originating function number |
| req_kind | input | 2 | Request kind (00 posted, 01 non-posted, 10 completion, 11 other) |
| req_tag | input | TAG_W | Request tag |
| req_rid | input | RID_W | Requester ID |
| req_data | input | DATA_W | Request payload |
| core_valid | output | 1 | Request to core valid |
| core_ready | input | 1 | Core accepts request |
| core_func | output | FUNC_W | Forwarded function number |
| core_kind | output | 2 | Forwarded kind |
| core_tag | output | TAG_W | Forwarded tag |
| core_rid | output | RID_W | Forwarded requester ID |
| core_data | output | DATA_W | Forwarded payload |
| errcpl_valid | output | 1 | Local error completion valid |
| errcpl_ready | input | 1 | Error completion accepted |
| errcpl_func | output | FUNC_W | Function of the dropped request |
| errcpl_tag | output | TAG_W | Tag of the dropped request |
| errcpl_rid | output | RID_W | Requester ID of the dropped request |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 stop bits, 1 debug flags |
| reg_wdata | input | REG_W | Write data, write-1-to-clear |
| reg_rdata | output | REG_W | Read data for the selected register |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume a few things about the inputs. `flr_enter` is low during the MAC reset. Request fields are stable while `req_valid` is high and `req_ready` is low. The PCIe core and the completion sink follow the valid/ready rule, so a taken completion is never re-offered.

The bench drives every input on the falling clock edge and drops `req_valid` once each transfer is accepted, which keeps the stimulus inside these assumptions. It sweeps every stop-bit pattern against every function number, including one past the last function, and every kind. Directed cases then cover completion backpressure, the same-cycle set/clear race and the soft reset.

// File: rtl/rsg_pkg.sv
`timescale 1ns/1ps
package rsg_pkg;
   typedef enum logic [1:0] {
      KIND_POSTED    = 2'b00,
      KIND_NONPOSTED = 2'b01,
      KIND_CPL       = 2'b10,
      KIND_OTHER     = 2'b11
   } req_kind_e;

   localparam logic REG_SEL_STOP = 1'b0;
   localparam logic REG_SEL_DBG  = 1'b1;
endpackage

// File: rtl/rsg_state.sv
`timescale 1ns/1ps
module rsg_state #(
   parameter int NFUNC      = 3,
   parameter int REG_W      = 64,
   parameter bit RDATA_FLOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFUNC-1:0] flr_enter,
   input  logic [NFUNC-1:0] discard_vec,
   input  logic             reg_wr_en,
   input  logic             reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [NFUNC-1:0] stop_o,
   output logic [NFUNC-1:0] dbg_o,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq_o
);
   import rsg_pkg::*;

   logic [NFUNC-1:0] stop_clr;
   logic [NFUNC-1:0] dbg_clr;
   logic [REG_W-1:0] rd_mux;

   assign stop_clr = (reg_wr_en && reg_addr == REG_SEL_STOP) ? reg_wdata[NFUNC-1:0] : '0;
   assign dbg_clr  = (reg_wr_en && reg_addr == REG_SEL_DBG)  ? reg_wdata[NFUNC-1:0] : '0;

   for (genvar gi = 0; gi < NFUNC; gi++) begin : g_func
      logic stop_bit_q;
      logic dbg_bit_q;

      // hardware set beats software clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 stop_bit_q <= 1'b0;
         else if (flr_enter[gi])     stop_bit_q <= 1'b1;
         else if (stop_clr[gi])      stop_bit_q <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 dbg_bit_q <= 1'b0;
         else if (discard_vec[gi])   dbg_bit_q <= 1'b1;
         else if (dbg_clr[gi])       dbg_bit_q <= 1'b0;
      end

      assign stop_o[gi] = stop_bit_q;
      assign dbg_o[gi]  = dbg_bit_q;
   end

   assign irq_o = |dbg_o;

   always_comb begin
      rd_mux = '0;
      rd_mux[NFUNC-1:0] = (reg_addr == REG_SEL_STOP) ? stop_o : dbg_o;
   end

   if (RDATA_FLOP) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) reg_rdata <= '0;
         else        reg_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign reg_rdata = rd_mux;
   end

   // R1
   flr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stop_o & $past(flr_enter)) == $past(flr_enter)));

   // R2
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stop_o & ($past(stop_o) & ~$past(stop_clr))) == ($past(stop_o) & ~$past(stop_clr))));

   // R7
   dbg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dbg_o & $past(discard_vec)) == $past(discard_vec)));

   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|discard_vec));
endmodule

// File: rtl/rsg_gate.sv
`timescale 1ns/1ps
module rsg_gate #(
   parameter int NFUNC  = 3,
   parameter int FUNC_W = 2
) (
   input  logic              in_valid,
   input  logic [FUNC_W-1:0] in_func,
   input  logic [1:0]        in_kind,
   input  logic [NFUNC-1:0]  stop_vec,
   input  logic              core_ready,
   input  logic              cpl_room,
   output logic              core_valid,
   output logic              in_ready,
   output logic              np_drop,
   output logic [NFUNC-1:0]  discard_vec
);
   import rsg_pkg::*;

   logic func_ok;
   logic stopped;
   logic gated_kind;
   logic is_np;
   logic drop_cand;
   logic drop_take;

   assign func_ok    = int'(in_func) < NFUNC;
   assign stopped    = func_ok ? stop_vec[in_func] : 1'b0;
   assign is_np      = (in_kind == KIND_NONPOSTED);
   assign gated_kind = (in_kind == KIND_POSTED) || is_np;
   assign drop_cand  = stopped && gated_kind;

   assign core_valid = in_valid && !drop_cand;
   assign in_ready   = drop_cand ? (is_np ? cpl_room : 1'b1) : core_ready;
   assign drop_take  = in_valid && drop_cand && in_ready;
   assign np_drop    = drop_take && is_np;

   always_comb begin
      for (int i = 0; i < NFUNC; i++) begin
         discard_vec[i] = drop_take && (int'(in_func) == i);
      end
   end
endmodule

// File: rtl/rsg_errcpl.sv
`timescale 1ns/1ps
module rsg_errcpl #(
   parameter int FUNC_W = 2,
   parameter int TAG_W  = 10,
   parameter int RID_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              push,
   input  logic [FUNC_W-1:0] push_func,
   input  logic [TAG_W-1:0]  push_tag,
   input  logic [RID_W-1:0]  push_rid,
   input  logic              pop_ready,
   output logic              valid_o,
   output logic [FUNC_W-1:0] func_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [RID_W-1:0]  rid_o,
   output logic              room_o
);
   logic              valid_q;
   logic [FUNC_W-1:0] func_q;
   logic [TAG_W-1:0]  tag_q;
   logic [RID_W-1:0]  rid_q;

   assign room_o = !soft_rst && (!valid_q || pop_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         valid_q <= 1'b0;
      else if (soft_rst)  valid_q <= 1'b0;
      else if (push)      valid_q <= 1'b1;
      else if (pop_ready) valid_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         func_q <= '0;
         tag_q  <= '0;
         rid_q  <= '0;
      end else if (push) begin
         func_q <= push_func;
         tag_q  <= push_tag;
         rid_q  <= push_rid;
      end
   end

   assign valid_o = valid_q;
   assign func_o  = func_q;
   assign tag_o   = tag_q;
   assign rid_o   = rid_q;

   // R5
   cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !pop_ready && !soft_rst) |=>
         (valid_q && $stable(tag_q) && $stable(rid_q) && $stable(func_q)));

   // R5
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!valid_q || pop_ready));

   // R9
   soft_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !valid_q);
endmodule

// File: rtl/req_stop_gate.sv
`timescale 1ns/1ps
module req_stop_gate #(
   parameter int NFUNC      = 3,
   parameter int FUNC_W     = (NFUNC > 1) ? $clog2(NFUNC) : 1,
   parameter int TAG_W      = 10,
   parameter int RID_W      = 16,
   parameter int DATA_W     = 32,
   parameter int REG_W      = 64,
   parameter bit RDATA_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [NFUNC-1:0]  flr_enter,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [1:0]        req_kind,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [RID_W-1:0]  req_rid,
   input  logic [DATA_W-1:0] req_data,
   output logic              core_valid,
   input  logic              core_ready,
   output logic [FUNC_W-1:0] core_func,
   output logic [1:0]        core_kind,
   output logic [TAG_W-1:0]  core_tag,
   output logic [RID_W-1:0]  core_rid,
   output logic [DATA_W-1:0] core_data,
   output logic              errcpl_valid,
   input  logic              errcpl_ready,
   output logic [FUNC_W-1:0] errcpl_func,
   output logic [TAG_W-1:0]  errcpl_tag,
   output logic [RID_W-1:0]  errcpl_rid,
   input  logic              reg_wr_en,
   input  logic              reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);
   import rsg_pkg::*;

   localparam int FUNC_SPAN = 1 << FUNC_W;

   if (NFUNC < 1 || NFUNC > REG_W) begin : g_bad_nfunc
      $error("req_stop_gate: NFUNC must lie in 1..REG_W");
   end
   if (FUNC_SPAN < NFUNC) begin : g_bad_funcw
      $error("req_stop_gate: FUNC_W too narrow for NFUNC");
   end
   if (TAG_W < 1 || RID_W < 1 || DATA_W < 1) begin : g_bad_fields
      $error("req_stop_gate: field widths must be positive");
   end

   logic [NFUNC-1:0] stop_vec;
   logic [NFUNC-1:0] dbg_vec;
   logic [NFUNC-1:0] discard_vec;
   logic             np_drop;
   logic             cpl_room;

   rsg_state #(
      .NFUNC      (NFUNC),
      .REG_W      (REG_W),
      .RDATA_FLOP (RDATA_FLOP)
   ) state_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flr_enter   (flr_enter),
      .discard_vec (discard_vec),
      .reg_wr_en   (reg_wr_en),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .stop_o      (stop_vec),
      .dbg_o       (dbg_vec),
      .reg_rdata   (reg_rdata),
      .irq_o       (irq)
   );

   rsg_gate #(
      .NFUNC  (NFUNC),
      .FUNC_W (FUNC_W)
   ) gate_i (
      .in_valid    (req_valid),
      .in_func     (req_func),
      .in_kind     (req_kind),
      .stop_vec    (stop_vec),
      .core_ready  (core_ready),
      .cpl_room    (cpl_room),
      .core_valid  (core_valid),
      .in_ready    (req_ready),
      .np_drop     (np_drop),
      .discard_vec (discard_vec)
   );

   rsg_errcpl #(
      .FUNC_W (FUNC_W),
      .TAG_W  (TAG_W),
      .RID_W  (RID_W)
   ) errcpl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .push      (np_drop),
      .push_func (req_func),
      .push_tag  (req_tag),
      .push_rid  (req_rid),
      .pop_ready (errcpl_ready),
      .valid_o   (errcpl_valid),
      .func_o    (errcpl_func),
      .tag_o     (errcpl_tag),
      .rid_o     (errcpl_rid),
      .room_o    (cpl_room)
   );

   assign core_func = req_func;
   assign core_kind = req_kind;
   assign core_tag  = req_tag;
   assign core_rid  = req_rid;
   assign core_data = req_data;

   logic chk_stopped;
   logic chk_gated;
   assign chk_stopped = (int'(req_func) < NFUNC) && stop_vec[req_func];
   assign chk_gated   = (req_kind == KIND_POSTED) || (req_kind == KIND_NONPOSTED);

   // R3
   no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_valid && chk_gated) |-> !chk_stopped);

   // R6
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_NONPOSTED && chk_stopped && errcpl_valid && !errcpl_ready)
         |-> !req_ready);

   // R5
   errcpl_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind == KIND_NONPOSTED && chk_stopped && !soft_rst)
         |=> (errcpl_valid && errcpl_tag == $past(req_tag) && errcpl_rid == $past(req_rid)));
endmodule

// File: tb/req_stop_gate_tb_top.sv
`timescale 1ns/1ps
module req_stop_gate_tb_top;
   localparam int NF = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [2:0]  flr_enter = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_func = '0;
   logic [1:0]  req_kind = '0;
   logic [9:0]  req_tag = '0;
   logic [15:0] req_rid = '0;
   logic [31:0] req_data = '0;
   logic        core_valid;
   logic        core_ready = 1'b1;
   logic [1:0]  core_func;
   logic [1:0]  core_kind;
   logic [9:0]  core_tag;
   logic [15:0] core_rid;
   logic [31:0] core_data;
   logic        errcpl_valid;
   logic        errcpl_ready = 1'b1;
   logic [1:0]  errcpl_func;
   logic [9:0]  errcpl_tag;
   logic [15:0] errcpl_rid;
   logic        reg_wr_en = 1'b0;
   logic        reg_addr = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   req_stop_gate dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flr_enter(flr_enter),
      .req_valid(req_valid), .req_ready(req_ready), .req_func(req_func),
      .req_kind(req_kind), .req_tag(req_tag), .req_rid(req_rid), .req_data(req_data),
      .core_valid(core_valid), .core_ready(core_ready), .core_func(core_func),
      .core_kind(core_kind), .core_tag(core_tag), .core_rid(core_rid), .core_data(core_data),
      .errcpl_valid(errcpl_valid), .errcpl_ready(errcpl_ready), .errcpl_func(errcpl_func),
      .errcpl_tag(errcpl_tag), .errcpl_rid(errcpl_rid),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic reg_read(input logic addr, output logic [63:0] val);
      @(negedge clk);
      reg_addr = addr;
      #1 val = reg_rdata;
   endtask

   task automatic reg_write(input logic addr, input logic [63:0] val);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = addr; reg_wdata = val;
      @(posedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wdata = '0;
   endtask

   task automatic mac_reset();
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic flr_pulse(input logic [2:0] m);
      @(negedge clk); flr_enter = m;
      @(posedge clk);
      @(negedge clk); flr_enter = '0;
   endtask

   task automatic drive(input int f, input int k, input int tg);
      req_valid = 1'b1;
      req_func  = 2'(f);
      req_kind  = 2'(k);
      req_tag   = 10'(tg);
      req_rid   = 16'(tg * 7 + 3);
      req_data  = 32'(tg * 1000 + 11);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] rd;
      logic [2:0]  exp_dbg;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R9 reset state
      reg_read(1'b0, rd); check("R9 stop after reset", rd, 64'h0);
      reg_read(1'b1, rd); check("R9 dbg after reset", rd, 64'h0);
      check("R9 irq after reset", 64'(irq), 64'h0);
      check("R9 errcpl after reset", 64'(errcpl_valid), 64'h0);

      for (int m = 0; m < 8; m++) begin
         mac_reset();
         flr_pulse(3'(m));
         reg_read(1'b0, rd);
         check("R1 stop bits after flr", rd, 64'(m));
         exp_dbg = '0;
         for (int f = 0; f < 4; f++) begin
            for (int k = 0; k < 4; k++) begin
               int  tg;
               logic stp, drp, npd;
               tg  = m * 16 + f * 4 + k;
               stp = (f < NF) && m[f];
               drp = stp && (k < 2);
               npd = drp && (k == 1);
               @(negedge clk);
               drive(f, k, tg);
               #1;
               check(drp ? "R3 drop core_valid" : "R4 pass core_valid", 64'(core_valid), 64'(!drp));
               check(drp ? "R3 drop ready" : "R4 pass ready", 64'(req_ready), 64'h1);
               if (!drp) begin
                  check("R4 tag copied", 64'(core_tag), 64'(tg));
                  check("R4 data copied", 64'(core_data), 64'(tg * 1000 + 11));
               end
               @(posedge clk);
               @(negedge clk);
               req_valid = 1'b0;
               #1;
               check("R5 errcpl issued", 64'(errcpl_valid), 64'(npd));
               if (npd) begin
                  check("R5 errcpl tag", 64'(errcpl_tag), 64'(tg));
                  check("R5 errcpl rid", 64'(errcpl_rid), 64'(16'(tg * 7 + 3)));
                  check("R5 errcpl func", 64'(errcpl_func), 64'(f));
               end
               if (drp) exp_dbg[f] = 1'b1;
            end
         end
         @(negedge clk); #1;
         check("R5 single errcpl", 64'(errcpl_valid), 64'h0);
         reg_read(1'b1, rd);
         check("R7 dbg flags", rd, 64'(exp_dbg));
         check("R8 irq level", 64'(irq), 64'(exp_dbg != 0));
      end

      // stop = 7, dbg = 7 here
      reg_write(1'b0, 64'h0);
      reg_read(1'b0, rd); check("R2 write zero keeps stop", rd, 64'h7);
      reg_write(1'b0, 64'hFFFF_FFFF_FFFF_FFF5);
      reg_read(1'b0, rd); check("R2 w1c stop", rd, 64'h2);
      reg_write(1'b1, 64'h0);
      reg_read(1'b1, rd); check("R7 write zero keeps dbg", rd, 64'h7);
      reg_write(1'b1, 64'h7);
      reg_read(1'b1, rd); check("R7 w1c dbg", rd, 64'h0);
      check("R8 irq cleared", 64'(irq), 64'h0);

      // same-cycle set and clear
      @(negedge clk);
      flr_enter = 3'b001; reg_wr_en = 1'b1; reg_addr = 1'b0; reg_wdata = 64'h1;
      @(posedge clk);
      @(negedge clk);
      flr_enter = '0; reg_wr_en = 1'b0; reg_wdata = '0;
      reg_read(1'b0, rd); check("R2 set beats clear", rd, 64'h3);

      // core backpressure
      @(negedge clk);
      core_ready = 1'b0; drive(2, 0, 900);
      #1;
      check("R4 stall on core_ready", 64'(req_ready), 64'h0);
      check("R4 valid while stalled", 64'(core_valid), 64'h1);
      drive(1, 0, 901);
      #1;
      check("R3 drop ignores core_ready", 64'(req_ready), 64'h1);
      check("R3 no forward", 64'(core_valid), 64'h0);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; core_ready = 1'b1;

      // completion backpressure
      errcpl_ready = 1'b0;
      drive(0, 1, 100);
      @(posedge clk);
      @(negedge clk);
      drive(1, 1, 200);
      #1;
      check("R6 np stalls", 64'(req_ready), 64'h0);
      drive(1, 0, 300);
      #1;
      check("R6 posted still drops", 64'(req_ready), 64'h1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check("R5 held tag", 64'(errcpl_tag), 64'd100);
      check("R5 held valid", 64'(errcpl_valid), 64'h1);
      drive(1, 1, 200);
      errcpl_ready = 1'b1;
      #1;
      check("R6 room on drain", 64'(req_ready), 64'h1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check("R5 next errcpl tag", 64'(errcpl_tag), 64'd200);
      @(posedge clk);

      // soft reset
      @(negedge clk);
      errcpl_ready = 1'b0;
      drive(0, 1, 400);
      @(posedge clk);
      @(negedge clk);
      soft_rst = 1'b1;
      drive(1, 1, 401);
      #1;
      check("R9 np stalls in soft reset", 64'(req_ready), 64'h0);
      @(posedge clk);
      @(negedge clk);
      soft_rst = 1'b0; req_valid = 1'b0;
      #1;
      check("R9 soft reset flushes errcpl", 64'(errcpl_valid), 64'h0);
      errcpl_ready = 1'b1;
      reg_read(1'b0, rd); check("R9 stop kept over soft reset", rd, 64'h3);
      reg_read(1'b1, rd); check("R9 dbg kept over soft reset", rd, 64'h3);
      check("R8 irq after drops", 64'(irq), 64'h1);

      mac_reset();
      reg_read(1'b0, rd); check("R9 mac reset stop", rd, 64'h0);
      reg_read(1'b1, rd); check("R9 mac reset dbg", rd, 64'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule